// File: doc/BRIEF.md
# Dual-Core Mailbox with Hardware Mutex

This peripheral lets two processor cores signal each other through shared registers on a 32-bit register bus. Each core owns one mailbox word and one interrupt line. The other core posts a message into that word in one of three ways:

- a full-word write, which replaces the value;
- a set write, which turns on the chosen bits;
- a clear write, which turns off the chosen bits.

The owner's interrupt stays high for as long as its mailbox holds a nonzero value. The owner acknowledges a message by clearing the bits it has handled.

A single hardware mutex lets the two cores share a resource. The mutex is a two-state machine: `MTX_FREE` and `MTX_HELD`.

- TAKE (`MTX_FREE` to `MTX_HELD`): a read of the mutex address while the mutex is free returns 1 and locks it.
- BUSY (stays in `MTX_HELD`): a read while the mutex is held returns 0 and changes nothing.
- RELEASE (`MTX_HELD` to `MTX_FREE`): a write with bit 0 set frees the mutex.
- RETAKE: a release write and a read in the same cycle are applied in that order. The read returns 1 and the mutex ends held.

All other accesses leave the state where it is.

Read data is combinational. It is valid in the same cycle as the read strobe. Register updates and the interrupt change take effect at the next rising clock edge.

Top module: `mbox_ipc_top`

## Requirements
- R1: After reset both mailboxes read 0, both interrupt lines are low, and the mutex is free (the first mutex read returns 1).
- R2: Mailbox i occupies a 16-byte slot at byte address 16*i. A write to slot word 0x0 replaces the whole 32-bit value. A read of slot word 0x0 returns the current value.
- R3: A write to slot word 0x4 ORs the written bits into the mailbox. Writing zero leaves it unchanged.
- R4: A write to slot word 0x8 clears exactly the bits written as 1. Writing zero leaves it unchanged.
- R5: `irq[i]` is high exactly when mailbox i is nonzero. It changes at the same clock edge as the mailbox value, so it falls only after a full-word write or a clear write.
- R6: A read of byte address 0xF8 returns 1 in bit 0 and locks the mutex if the mutex was free. If the mutex is held, the read returns 0 and the mutex stays held.
- R7: A write to 0xF8 with bit 0 = 1 frees the mutex. A write with bit 0 = 0 has no effect.
- R8: A release write and a read of 0xF8 in the same cycle: the release is applied first, so the read returns 1 and the mutex ends held.
- R9: Reads of write-only words (0x4, 0x8), reserved words (0xC, unused slots 0x20–0xEF, 0xF0, 0xF4, 0xFC) and addresses not word-aligned return 0 and do not change the mutex.
- R10: Writes to reserved or unaligned addresses change neither mailbox nor either interrupt line.
- R11: `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 2 | Per-mailbox interrupt, bit i for mailbox i |

## Verification
The embedded assertions check the following on every cycle:
- each mailbox update rule (replace, OR, masked clear, hold when not addressed);
- that an interrupt falls only after a full-word or clear write;
- every mutex transition, including the release-then-read order;
- that at most one read source is selected;
- that idle read data is zero.

Some behaviours can be shown only by the bench's directed scenarios: the address map itself, the zero data returned from reserved and write-only words, the absence of side effects from stray reads and writes, and which interrupt line follows which mailbox.

// File: rtl/mbox_ipc_pkg.sv
package mbox_ipc_pkg;

    // Word position inside a 16-byte mailbox slot (address bits [3:2]).
    typedef enum logic [1:0] {
        SLOT_DATA = 2'd0,
        SLOT_SET  = 2'd1,
        SLOT_CLR  = 2'd2,
        SLOT_RSVD = 2'd3
    } slot_word_e;

    typedef enum logic {
        MTX_FREE = 1'b0,
        MTX_HELD = 1'b1
    } mtx_state_e;

    typedef struct packed {
        logic wr_full;
        logic wr_set;
        logic wr_clr;
    } box_wr_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_ipc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BOX   = 2,
    parameter int MUTEX_OFS = 248
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output box_wr_t           wsel [NUM_BOX],
    output logic [NUM_BOX-1:0] rd_hit,
    output logic              mtx_rd,
    output logic              mtx_wr
);
    localparam int SLOT_W = ADDR_W - 4;

    logic       aligned;
    logic       mtx_hit;
    slot_word_e word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = slot_word_e'(addr[3:2]);
    assign mtx_hit = (addr == ADDR_W'(MUTEX_OFS));
    assign mtx_rd  = re && mtx_hit;
    assign mtx_wr  = we && mtx_hit;

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
        logic hit;
        assign hit             = aligned && (addr[ADDR_W-1:4] == SLOT_W'(i));
        assign wsel[i].wr_full = hit && we && (word == SLOT_DATA);
        assign wsel[i].wr_set  = hit && we && (word == SLOT_SET);
        assign wsel[i].wr_clr  = hit && we && (word == SLOT_CLR);
        assign rd_hit[i]       = hit && re && (word == SLOT_DATA);
    end

    // R9: at most one read source is selected at a time
    always_comb begin
        a_r9_one_read_source: assert ($onehot0({mtx_rd, rd_hit}));
    end

endmodule

// File: rtl/mbox_word.sv
module mbox_word
    import mbox_ipc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  box_wr_t           wsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (wsel.wr_full)
            value <= wdata;
        else if (wsel.wr_set)
            value <= value | wdata;
        else if (wsel.wr_clr)
            value <= value & ~wdata;
    end

    assign irq = |value;

    a_r2_full_replace: assert property (@(posedge clk) disable iff (!rst_n)
        wsel.wr_full |=> value == $past(wdata));

    a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        wsel.wr_set |=> value == ($past(value) | $past(wdata)));

    a_r4_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wsel.wr_clr |=> value == ($past(value) & ~$past(wdata)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wsel.wr_full || wsel.wr_set || wsel.wr_clr) |=> $stable(value));

    a_r5_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wsel.wr_full || wsel.wr_clr));

endmodule

// File: rtl/mbox_mutex.sv
module mbox_mutex
    import mbox_ipc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic grant
);
    mtx_state_e state, state_nxt;
    logic       rel;

    assign rel = wr && wbit;

    // Next state: release is applied before a read in the same cycle.
    always_comb begin
        state_nxt = state;
        unique case (state)
            MTX_FREE: if (rd)        state_nxt = MTX_HELD;  // TAKE
            MTX_HELD: if (rel && !rd) state_nxt = MTX_FREE; // RELEASE
            default:                 state_nxt = MTX_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MTX_FREE;
        else        state <= state_nxt;
    end

    // Outputs: read returns 1 if free after any same-cycle release.
    always_comb begin
        grant = 1'b0;
        unique case (state)
            MTX_FREE: grant = rd;
            MTX_HELD: grant = rd && rel;   // RETAKE
            default:  grant = 1'b0;
        endcase
    end

    a_r6_take_locks: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> state == MTX_HELD);

    a_r6_busy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && state == MTX_HELD && !rel) |-> !grant);

    a_r7_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !rd) |=> state == MTX_FREE);

    a_r7_zero_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wbit && !rd) |=> $stable(state));

    a_r8_release_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rel) |-> grant);

endmodule

// File: rtl/mbox_ipc_top.sv
module mbox_ipc_top
    import mbox_ipc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_BOX   = 2,
    parameter int MUTEX_OFS = 248
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_re,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_BOX-1:0] irq
);
    box_wr_t              wsel    [NUM_BOX];
    logic [NUM_BOX-1:0]   rd_hit;
    logic                 mtx_rd;
    logic                 mtx_wr;
    logic                 mtx_grant;
    logic [DATA_W-1:0]    box_val [NUM_BOX];

    mbox_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BOX  (NUM_BOX),
        .MUTEX_OFS(MUTEX_OFS)
    ) u_decode (
        .addr  (bus_addr),
        .we    (bus_we),
        .re    (bus_re),
        .wsel  (wsel),
        .rd_hit(rd_hit),
        .mtx_rd(mtx_rd),
        .mtx_wr(mtx_wr)
    );

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
        mbox_word #(.DATA_W(DATA_W)) u_word (
            .clk  (clk),
            .rst_n(rst_n),
            .wsel (wsel[i]),
            .wdata(bus_wdata),
            .value(box_val[i]),
            .irq  (irq[i])
        );
    end

    mbox_mutex u_mutex (
        .clk  (clk),
        .rst_n(rst_n),
        .rd   (mtx_rd),
        .wr   (mtx_wr),
        .wbit (bus_wdata[0]),
        .grant(mtx_grant)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_BOX; i++)
            if (rd_hit[i]) bus_rdata = box_val[i];
        if (mtx_rd) bus_rdata = {{(DATA_W-1){1'b0}}, mtx_grant};
    end

    a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> bus_rdata == '0);

endmodule

// File: tb/mbox_ipc_top_tb.sv
module mbox_ipc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    mbox_ipc_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        chk("R1 irq after reset", {30'd0, irq}, 32'd0);
        bus_rd(8'h00, d); chk("R1 box0 after reset", d, 32'd0);
        bus_rd(8'h10, d); chk("R1 box1 after reset", d, 32'd0);
        bus_rd(8'hF8, d); chk("R1 first mutex read", d, 32'd1);
        bus_wr(8'hF8, 32'd1);
    endtask

    task automatic t_full_word();
        logic [31:0] d;
        bus_wr(8'h10, 32'hA5A5_0001);
        bus_rd(8'h10, d); chk("R2 box1 full write", d, 32'hA5A5_0001);
        chk("R5 only irq1 high", {30'd0, irq}, 32'd2);
        bus_wr(8'h00, 32'h8000_0000);
        bus_rd(8'h00, d); chk("R2 box0 full write", d, 32'h8000_0000);
        chk("R5 both irq high", {30'd0, irq}, 32'd3);
        bus_wr(8'h10, 32'h0000_0000);
        bus_rd(8'h10, d); chk("R2 box1 full write zero", d, 32'd0);
        chk("R5 irq1 drops on zero write", {30'd0, irq}, 32'd1);
    endtask

    task automatic t_set_alias();
        logic [31:0] d;
        bus_wr(8'h04, 32'h0000_00F0);
        bus_rd(8'h00, d); chk("R3 set ORs bits", d, 32'h8000_00F0);
        bus_wr(8'h04, 32'h0000_0000);
        bus_rd(8'h00, d); chk("R3 set zero no change", d, 32'h8000_00F0);
        bus_wr(8'h14, 32'h0000_0004);
        bus_rd(8'h10, d); chk("R3 set box1", d, 32'h0000_0004);
        chk("R5 irq1 raised by set", {31'd0, irq[1]}, 32'd1);
    endtask

    task automatic t_clr_alias();
        logic [31:0] d;
        bus_wr(8'h08, 32'h8000_0030);
        bus_rd(8'h00, d); chk("R4 clear masked bits", d, 32'h0000_00C0);
        bus_wr(8'h08, 32'h0000_0000);
        bus_rd(8'h00, d); chk("R4 clear zero no change", d, 32'h0000_00C0);
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_rd(8'h00, d); chk("R4 clear all", d, 32'd0);
        chk("R5 irq0 drops on clear", {31'd0, irq[0]}, 32'd0);
        bus_wr(8'h18, 32'h0000_0004);
        chk("R5 irq1 drops on clear", {31'd0, irq[1]}, 32'd0);
    endtask

    task automatic t_mutex();
        logic [31:0] d;
        bus_rd(8'hF8, d); chk("R6 take free mutex", d, 32'd1);
        bus_rd(8'hF8, d); chk("R6 read held mutex", d, 32'd0);
        bus_wr(8'hF8, 32'hFFFF_FFFE);
        bus_rd(8'hF8, d); chk("R7 write bit0=0 ignored", d, 32'd0);
        bus_wr(8'hF8, 32'd1);
        bus_rd(8'hF8, d); chk("R7 release then take", d, 32'd1);
        bus_wr(8'hF8, 32'd1);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        bus_rd(8'hF8, d);   // take
        @(negedge clk);
        bus_addr = 8'hF8; bus_wdata = 32'd1; bus_we = 1'b1; bus_re = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_re = 1'b0;
        chk("R8 release+read returns 1", d, 32'd1);
        bus_rd(8'hF8, d); chk("R8 mutex ends held", d, 32'd0);
        bus_wr(8'hF8, 32'd1);
    endtask

    task automatic t_reserved_reads();
        logic [31:0] d;
        logic [7:0] addrs [9] = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h20,
                                  8'hF0, 8'hF4, 8'hFC, 8'hF9};
        bus_wr(8'h00, 32'h1234_5678);
        bus_wr(8'h14, 32'h0000_00FF);
        for (int k = 0; k < 9; k++) begin
            bus_rd(addrs[k], d);
            chk($sformatf("R9 read %h returns 0", addrs[k]), d, 32'd0);
        end
        bus_rd(8'h01, d); chk("R9 unaligned read 0", d, 32'd0);
        bus_rd(8'hF8, d); chk("R9 mutex untouched by stray reads", d, 32'd1);
        bus_wr(8'hF8, 32'd1);
    endtask

    task automatic t_reserved_writes();
        logic [31:0] d;
        logic [7:0] addrs [6] = '{8'h0C, 8'h1C, 8'h20, 8'hF4, 8'h01, 8'hE8};
        for (int k = 0; k < 6; k++) bus_wr(addrs[k], 32'hFFFF_FFFF);
        bus_rd(8'h00, d); chk("R10 box0 unchanged", d, 32'h1234_5678);
        bus_rd(8'h10, d); chk("R10 box1 unchanged", d, 32'h0000_00FF);
        bus_wr(8'h00, 32'd0);
        bus_wr(8'h10, 32'd0);
        bus_wr(8'h2C, 32'hFFFF_FFFF);
        bus_wr(8'hF0, 32'hFFFF_FFFF);
        chk("R10 irq stays low", {30'd0, irq}, 32'd0);
    endtask

    task automatic t_idle_read();
        bus_wr(8'h00, 32'hDEAD_BEEF);
        @(negedge clk);
        bus_addr = 8'h00; bus_re = 1'b0;
        #2 chk("R11 rdata zero when idle", bus_rdata, 32'd0);
        @(negedge clk);
        bus_addr = 8'hF8;
        #2 chk("R11 idle mutex address zero", bus_rdata, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_full_word();
        t_set_alias();
        t_clr_alias();
        t_mutex();
        t_same_cycle();
        t_reserved_reads();
        t_reserved_writes();
        t_idle_read();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=timeout exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule